// File: doc/BRIEF.md
# Funnel Shift Unit

This unit is the shift stage of an integer datapath. Two operands of `OPW` bits are joined into one double-width value, with `lo_i` in the lower half and `hi_i` in the upper half. The joined value is shifted left or right by an amount given on `amt_i`, and one half of the shifted value is returned. The upper half comes back after a left shift and the lower half after a right shift. This lets a pair of registers act as one wide operand, and the result is written to a single destination.

The control comes from an already-fetched 64-bit instruction word on `insn_i`. From it the unit takes:
- the destination index,
- a 2-bit ceiling mode, which sets the largest shift and the signedness,
- a wrap flag, which either masks the amount or clamps it to the ceiling,
- two fields that this unit does not implement.

Any encoding the unit cannot execute raises `err_o` and produces no result. The result, the destination index and the two strobes are registered, so they appear one clock after `valid_i`.

Top module: `funnel_shift_unit`

## Requirements
- R1: The working value is `{hi_i, lo_i}`, with `lo_i` in the lower `OPW` bits. With an effective amount of zero, a right shift returns `lo_i` and a left shift returns `hi_i`.
- R2: The mode field is instruction bits 38:37. Code 0 gives a ceiling of `OPW`, and codes 2 and 3 give a ceiling of `2*OPW-1`. When the wrap flag (bit 50) is 0, the effective amount is the unsigned minimum of `amt_i` and the ceiling.
- R3: When the wrap flag (bit 50) is 1, the effective amount is `amt_i` ANDed with (ceiling - 1).
- R4: A left shift (`right_i` = 0) is logical in every mode, fills with zeros, and returns the upper `OPW` bits of the shifted value.
- R5: A right shift (`right_i` = 1) returns the lower `OPW` bits of the shifted value. It is arithmetic, copying bit `OPW-1` of `hi_i` into the vacated bits, only in mode code 3. In codes 0 and 2 it is logical.
- R6: Any of the following makes the encoding unsupported: mode code 1, bit 47 set, or a nonzero value in bits 49:48. An unsupported encoding with `valid_i` set gives `err_o` = 1 and `valid_o` = 0 on the next clock, and `res_o` and `dst_o` keep their previous values.
- R7: A supported encoding with `valid_i` set gives `valid_o` = 1 and `err_o` = 0 one clock later. On the same clock `res_o` carries the result and `dst_o` carries instruction bits 7:0.
- R8: While `rst_ni` is low, `valid_o`, `err_o`, `res_o` and `dst_o` are all zero.
- R9: In a cycle without `valid_i`, the next clock gives `valid_o` = 0 and `err_o` = 0, and `res_o` and `dst_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| insn_i | input | 64 | Instruction word holding the destination, mode, wrap and unsupported fields |
| right_i | input | 1 | 1 shifts right, 0 shifts left |
| amt_i | input | AMTW | Raw shift amount, from a register or an immediate |
| lo_i | input | OPW | Low operand |
| hi_i | input | OPW | High operand |
| valid_o | output | 1 | Result strobe, one clock after a supported operation |
| err_o | output | 1 | Unsupported-encoding strobe, one clock after the operation |
| res_o | output | OPW | Returned half of the shifted value |
| dst_o | output | 8 | Destination index of the last result |

## Verification
The bench builds the unit with `OPW` = 8 and `AMTW` = 32. The ceilings then fall at 8 and 15, so sweeping amounts 0 to 17 covers, for both ceilings, the amounts below, at and just above the ceiling in both wrap and clamp. Full-width amounts such as `32'hFFFFFFFF` exercise the clamp and the mask on large inputs. Eight operand patterns per side, all pairs taken, put sign bits in both halves, so the mode-3 sign fill and the logical fill of the other modes are told apart at every amount.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int unsigned INSN_W    = 64;
  localparam int unsigned REG_IDX_W = 8;
  // field positions inside the instruction word
  localparam int unsigned DST_LSB   = 0;
  localparam int unsigned SRC_LSB   = 8;
  localparam int unsigned MODE_LSB  = 37;
  localparam int unsigned CC_BIT    = 47;
  localparam int unsigned XM_LSB    = 48;
  localparam int unsigned WRAP_BIT  = 50;

  typedef enum logic [1:0] {
    CEIL_NARROW = 2'd0,
    CEIL_RSVD   = 2'd1,
    CEIL_WIDE_U = 2'd2,
    CEIL_WIDE_S = 2'd3
  } ceil_mode_e;

  typedef struct packed {
    logic [REG_IDX_W-1:0] dst;
    ceil_mode_e           mode;
    logic                 cc_en;
    logic [1:0]           xmode;
    logic                 wrap;
  } fsh_ctl_t;
endpackage

// File: rtl/fsh_decode.sv
module fsh_decode
  import fsh_pkg::*;
(
  input  logic [INSN_W-1:0]    insn_i,
  output logic [REG_IDX_W-1:0] dst_o,
  output ceil_mode_e           mode_o,
  output logic                 wrap_o,
  output logic                 legal_o
);
  fsh_ctl_t ctl;

  always_comb begin
    ctl.dst   = insn_i[DST_LSB +: REG_IDX_W];
    ctl.mode  = ceil_mode_e'(insn_i[MODE_LSB +: 2]);
    ctl.cc_en = insn_i[CC_BIT];
    ctl.xmode = insn_i[XM_LSB +: 2];
    ctl.wrap  = insn_i[WRAP_BIT];
  end

  assign dst_o   = ctl.dst;
  assign mode_o  = ctl.mode;
  assign wrap_o  = ctl.wrap;
  assign legal_o = (ctl.mode != CEIL_RSVD) && !ctl.cc_en && (ctl.xmode == 2'b00);

  // source index and reserved bits are consumed elsewhere
  logic unused_insn_bits;
  assign unused_insn_bits = ^{insn_i[INSN_W-1:WRAP_BIT+1],
                              insn_i[CC_BIT-1:MODE_LSB+2],
                              insn_i[MODE_LSB-1:SRC_LSB]};
endmodule

// File: rtl/fsh_amount.sv
module fsh_amount
  import fsh_pkg::*;
#(
  parameter int unsigned OPW  = 32,
  parameter int unsigned AMTW = 32,
  parameter int unsigned SHW  = 6
) (
  input  logic [AMTW-1:0] amt_i,
  input  ceil_mode_e      mode_i,
  input  logic            wrap_i,
  output logic [SHW-1:0]  eff_o
);
  localparam logic [AMTW-1:0] CEIL_N = AMTW'(OPW);
  localparam logic [AMTW-1:0] CEIL_W = AMTW'(2 * OPW - 1);

  logic [AMTW-1:0] ceil_v;
  logic [AMTW-1:0] masked;
  logic [AMTW-1:0] clamped;
  logic [AMTW-1:0] sel;

  always_comb begin
    ceil_v  = (mode_i == CEIL_NARROW) ? CEIL_N : CEIL_W;
    masked  = amt_i & (ceil_v - AMTW'(1));
    clamped = (amt_i < ceil_v) ? amt_i : ceil_v;
    sel     = wrap_i ? masked : clamped;
  end

  // both paths stay below 2*OPW, so the upper bits are always zero
  assign eff_o = sel[SHW-1:0];

  logic unused_sel_hi;
  assign unused_sel_hi = ^sel[AMTW-1:SHW];
endmodule

// File: rtl/fsh_core.sv
module fsh_core #(
  parameter int unsigned OPW = 32,
  parameter int unsigned SHW = 6
) (
  input  logic [OPW-1:0] lo_i,
  input  logic [OPW-1:0] hi_i,
  input  logic           right_i,
  input  logic           arith_i,
  input  logic [SHW-1:0] amt_i,
  output logic [OPW-1:0] res_o
);
  localparam int unsigned W = 2 * OPW;

  logic [W-1:0] joined;
  logic [W-1:0] fwd;
  logic [W-1:0] back;
  logic [W-1:0] stg [SHW+1];
  logic         fill;

  assign joined = {hi_i, lo_i};
  assign fill   = right_i & arith_i & hi_i[OPW-1];

  // left shift runs through the same right-shifting barrel, bit-reversed
  for (genvar b = 0; b < W; b++) begin : g_rev
    assign fwd[b]  = right_i ? joined[b]   : joined[W-1-b];
    assign back[b] = right_i ? stg[SHW][b] : stg[SHW][W-1-b];
  end

  assign stg[0] = fwd;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{STEP{fill}}, stg[k][W-1:STEP]} : stg[k];
  end

  assign res_o = right_i ? back[OPW-1:0] : back[W-1:OPW];
endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
  import fsh_pkg::*;
#(
  parameter int unsigned OPW  = 32,
  parameter int unsigned AMTW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [INSN_W-1:0]    insn_i,
  input  logic                 right_i,
  input  logic [AMTW-1:0]      amt_i,
  input  logic [OPW-1:0]       lo_i,
  input  logic [OPW-1:0]       hi_i,
  output logic                 valid_o,
  output logic                 err_o,
  output logic [OPW-1:0]       res_o,
  output logic [REG_IDX_W-1:0] dst_o
);
  localparam int unsigned SHW = $clog2(2 * OPW);

  logic [REG_IDX_W-1:0] dec_dst;
  ceil_mode_e           dec_mode;
  logic                 dec_wrap;
  logic                 dec_legal;
  logic [SHW-1:0]       eff_amt;
  logic [OPW-1:0]       shf_res;

  logic                 valid_q;
  logic                 err_q;
  logic [OPW-1:0]       res_q;
  logic [REG_IDX_W-1:0] dst_q;

  fsh_decode u_decode (
    .insn_i  (insn_i),
    .dst_o   (dec_dst),
    .mode_o  (dec_mode),
    .wrap_o  (dec_wrap),
    .legal_o (dec_legal)
  );

  fsh_amount #(
    .OPW  (OPW),
    .AMTW (AMTW),
    .SHW  (SHW)
  ) u_amount (
    .amt_i  (amt_i),
    .mode_i (dec_mode),
    .wrap_i (dec_wrap),
    .eff_o  (eff_amt)
  );

  fsh_core #(
    .OPW (OPW),
    .SHW (SHW)
  ) u_core (
    .lo_i    (lo_i),
    .hi_i    (hi_i),
    .right_i (right_i),
    .arith_i (dec_mode == CEIL_WIDE_S),
    .amt_i   (eff_amt),
    .res_o   (shf_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
      dst_q   <= '0;
    end else begin
      valid_q <= valid_i & dec_legal;
      err_q   <= valid_i & ~dec_legal;
      if (valid_i && dec_legal) begin
        res_q <= shf_res;
        dst_q <= dec_dst;
      end
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign res_o   = res_q;
  assign dst_o   = dst_q;
endmodule

// File: rtl/fsh_chk.sv
module fsh_chk
  import fsh_pkg::*;
#(
  parameter int unsigned OPW  = 32,
  parameter int unsigned AMTW = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [INSN_W-1:0]    insn_i,
  input logic                 right_i,
  input logic [AMTW-1:0]      amt_i,
  input logic [OPW-1:0]       lo_i,
  input logic [OPW-1:0]       hi_i,
  input logic                 valid_o,
  input logic                 err_o,
  input logic [OPW-1:0]       res_o,
  input logic [REG_IDX_W-1:0] dst_o
);
  logic       ok_enc;
  logic       go;
  logic [1:0] m;
  logic       w;

  assign m      = insn_i[MODE_LSB +: 2];
  assign w      = insn_i[WRAP_BIT];
  assign ok_enc = (m != 2'd1) && !insn_i[CC_BIT] && (insn_i[XM_LSB +: 2] == 2'b00);
  assign go     = valid_i && ok_enc;

  logic unused_chk_insn;
  assign unused_chk_insn = ^insn_i;

  // R6
  bad_enc_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ok_enc |=> err_o && !valid_o);

  // R6
  bad_enc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ok_enc |=> $stable(res_o) && $stable(dst_o));

  // R7
  result_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> valid_o && !err_o && (dst_o == $past(insn_i[DST_LSB +: REG_IDX_W])));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !err_o && $stable(res_o) && $stable(dst_o));

  // R4
  left_zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !right_i && (amt_i == '0) |=> res_o == $past(hi_i));

  // R5
  right_zero_amt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && right_i && (amt_i == '0) |=> res_o == $past(lo_i));

  // R2
  clamp_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !w && (m == 2'd0) && right_i && (amt_i >= AMTW'(OPW)) |=> res_o == $past(hi_i));

  // R3
  wrap_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && w && (m == 2'd0) && right_i && (amt_i == AMTW'(OPW)) |=> res_o == $past(lo_i));

  // R5
  sign_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !w && (m == 2'd3) && right_i && (amt_i >= AMTW'(2 * OPW - 1))
    |=> res_o == {OPW{$past(hi_i[OPW-1])}});

  // R6
  strobes_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));
endmodule

bind funnel_shift_unit fsh_chk #(
  .OPW  (OPW),
  .AMTW (AMTW)
) u_fsh_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .insn_i  (insn_i),
  .right_i (right_i),
  .amt_i   (amt_i),
  .lo_i    (lo_i),
  .hi_i    (hi_i),
  .valid_o (valid_o),
  .err_o   (err_o),
  .res_o   (res_o),
  .dst_o   (dst_o)
);

// File: tb/funnel_shift_unit_bench.sv
module funnel_shift_unit_bench;
  localparam int unsigned OPW  = 8;
  localparam int unsigned AMTW = 32;

  logic            clk_i   = 1'b0;
  logic            rst_ni  = 1'b1;
  logic            valid_i = 1'b0;
  logic [63:0]     insn_i  = '0;
  logic            right_i = 1'b0;
  logic [AMTW-1:0] amt_i   = '0;
  logic [OPW-1:0]  lo_i    = '0;
  logic [OPW-1:0]  hi_i    = '0;
  logic            valid_o;
  logic            err_o;
  logic [OPW-1:0]  res_o;
  logic [7:0]      dst_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  logic [OPW-1:0] exp_res = '0;
  logic [7:0]     exp_dst = '0;

  always #10 clk_i = ~clk_i;

  funnel_shift_unit #(.OPW(OPW), .AMTW(AMTW)) u_funnel_shift_unit (
    .clk_i, .rst_ni, .valid_i, .insn_i, .right_i, .amt_i, .lo_i, .hi_i,
    .valid_o, .err_o, .res_o, .dst_o
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_insn(logic [1:0] mode, logic wrap, logic cc,
                                          logic [1:0] xm, logic [7:0] dst);
    logic [63:0] w = 64'h0000_0000_1234_5600;
    w[7:0]   = dst;
    w[38:37] = mode;
    w[47]    = cc;
    w[49:48] = xm;
    w[50]    = wrap;
    return w;
  endfunction

  function automatic logic [OPW-1:0] ref_shift(logic [OPW-1:0] lo, logic [OPW-1:0] hi,
                                               logic right, logic [1:0] mode, logic wrap,
                                               logic [AMTW-1:0] amt);
    longint ceil_v = (mode == 2'd0) ? longint'(OPW) : longint'(2 * OPW - 1);
    longint a      = longint'({32'b0, amt});
    longint eff;
    longint v;
    logic [2*OPW-1:0] p = {hi, lo};
    eff = wrap ? (a & (ceil_v - 1)) : ((a < ceil_v) ? a : ceil_v);
    v   = (right && mode == 2'd3) ? longint'($signed(p)) : longint'({48'b0, p});
    if (right) begin
      v = v >>> eff;
      return v[OPW-1:0];
    end
    v = v << eff;
    return v[2*OPW-1:OPW];
  endfunction

  // drive at a falling edge, sample at the next falling edge
  task automatic run_op(input logic [1:0] mode, input logic wrap, input logic cc,
                        input logic [1:0] xm, input logic right, input logic [AMTW-1:0] amt,
                        input logic [OPW-1:0] lo, input logic [OPW-1:0] hi,
                        input logic [7:0] dst, input string req);
    bit legal = (mode != 2'd1) && !cc && (xm == 2'b00);
    valid_i = 1'b1;
    insn_i  = mk_insn(mode, wrap, cc, xm, dst);
    right_i = right;
    amt_i   = amt;
    lo_i    = lo;
    hi_i    = hi;
    if (legal) begin
      exp_res = ref_shift(lo, hi, right, mode, wrap, amt);
      exp_dst = dst;
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    check((valid_o == legal) && (err_o == !legal),
          legal ? "R7 strobes" : "R6 strobes", {valid_o, err_o}, {legal, !legal});
    check(res_o == exp_res, req, res_o, exp_res);
    check(dst_o == exp_dst, legal ? "R7 dst" : "R6 dst", dst_o, exp_dst);
  endtask

  initial begin
    repeat (120000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [OPW-1:0]  pats [8] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h81, 8'h7E, 8'h01, 8'h80};
    logic [AMTW-1:0] bigs [3] = '{32'd255, 32'h8000_0000, 32'hFFFF_FFFF};
    logic [1:0]      modes [3] = '{2'd0, 2'd2, 2'd3};

    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    // R8
    check({valid_o, err_o, res_o, dst_o} == '0, "R8 reset", {valid_o, err_o, res_o, dst_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: zero amount exposes the packing
    run_op(2'd0, 1'b0, 1'b0, 2'b00, 1'b1, 32'd0, 8'h3C, 8'hC3, 8'h11, "R1 right");
    run_op(2'd2, 1'b0, 1'b0, 2'b00, 1'b0, 32'd0, 8'h3C, 8'hC3, 8'h12, "R1 left");
    run_op(2'd3, 1'b1, 1'b0, 2'b00, 1'b1, 32'd0, 8'h96, 8'h69, 8'h13, "R1 right wrap");

    // R2 R3 R4 R5 sweep
    for (int mi = 0; mi < 3; mi++) begin
      for (int d = 0; d < 2; d++) begin
        for (int wr = 0; wr < 2; wr++) begin
          for (int ai = 0; ai < 21; ai++) begin
            for (int li = 0; li < 8; li++) begin
              for (int hi = 0; hi < 8; hi++) begin
                logic [AMTW-1:0] amt = (ai < 18) ? AMTW'(ai) : bigs[ai-18];
                string tag = $sformatf("%s %s mode%0d amt%0h",
                                       wr ? "R3" : "R2", d ? "R5" : "R4", modes[mi], amt);
                run_op(modes[mi], wr[0], 1'b0, 2'b00, d[0], amt, pats[li], pats[hi],
                       8'(ai * 8 + li), tag);
              end
            end
          end
        end
      end
    end

    // R6: each unsupported encoding
    run_op(2'd1, 1'b0, 1'b0, 2'b00, 1'b1, 32'd3, 8'hAA, 8'h55, 8'h21, "R6 mode1");
    run_op(2'd1, 1'b1, 1'b0, 2'b00, 1'b0, 32'd3, 8'hAA, 8'h55, 8'h22, "R6 mode1 wrap");
    run_op(2'd0, 1'b0, 1'b1, 2'b00, 1'b1, 32'd1, 8'h0F, 8'hF0, 8'h23, "R6 cc");
    run_op(2'd2, 1'b0, 1'b0, 2'b01, 1'b0, 32'd1, 8'h0F, 8'hF0, 8'h24, "R6 xmode1");
    run_op(2'd3, 1'b0, 1'b0, 2'b10, 1'b1, 32'd1, 8'h0F, 8'hF0, 8'h25, "R6 xmode2");
    run_op(2'd0, 1'b1, 1'b0, 2'b11, 1'b0, 32'd1, 8'h0F, 8'hF0, 8'h26, "R6 xmode3");
    run_op(2'd3, 1'b0, 1'b0, 2'b00, 1'b1, 32'd2, 8'h40, 8'h80, 8'h27, "R5 after R6");

    // R9: idle cycle with changed inputs
    insn_i  = mk_insn(2'd0, 1'b0, 1'b0, 2'b00, 8'hEE);
    lo_i    = 8'h13;
    hi_i    = 8'h37;
    amt_i   = 32'd4;
    right_i = 1'b0;
    @(negedge clk_i);
    check(!valid_o && !err_o, "R9 strobes", {valid_o, err_o}, 0);
    check(res_o == exp_res && dst_o == exp_dst, "R9 hold", {res_o, dst_o}, {exp_res, exp_dst});

    // R8: reset in mid-run
    run_op(2'd2, 1'b0, 1'b0, 2'b00, 1'b0, 32'd5, 8'hFF, 8'h01, 8'h99, "R4 before reset");
    rst_ni = 1'b0;
    #1;
    check({valid_o, err_o, res_o, dst_o} == '0, "R8 mid reset", {valid_o, err_o, res_o, dst_o}, 0);
    exp_res = '0;
    exp_dst = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_op(2'd0, 1'b0, 1'b0, 2'b00, 1'b1, 32'd9, 8'h00, 8'hA0, 8'h31, "R2 after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule